// File: doc/BRIEF.md
# Per-Bit Acknowledged Serial Link

This block moves bytes over three shared wires, one bit at a time. A sender puts a bit on the data wire and then pulls a strobe wire. A receiver takes the bit and answers on a separate acknowledge wire. The sender offers no further bit until it has seen the acknowledge assert and then release. Because of this full four-phase handshake there is no fixed bit period: the transfer runs exactly as fast as the slower party allows.

A higher-level exchange decides beforehand which end transmits, so each end holds one shift register and a role input that selects between sending and receiving. On the parallel side, a sender takes bytes through a valid/ready handshake and a receiver reports each completed byte with a one-cycle valid pulse. The wires are modelled as open-drain: each one has a pull-low enable output and a sensed-level input. A programmable wait limit guards every handshake wait. When the limit is exceeded the byte is abandoned, every wire is released and a sticky flag is raised.

Top module: `ackSerialLink`

## Requirements
- R1: All three wires are active-low and open-drain. The block only drives a pull-low enable for each wire and reads its level, and a wire counts as asserted when it reads 0. A data bit of value 1 is sent by pulling the data wire low, and a bit of value 0 leaves it released.
- R2: In the sender role, the data wire carries the current bit for at least one full cycle before the strobe is pulled. The data wire stays unchanged from then until the acknowledge has released again.
- R3: In the sender role, the strobe stays asserted until the acknowledge is seen low, and it is released in the cycle after that. The next bit is not presented, and no new strobe appears, until the acknowledge reads high again.
- R4: In the receiver role, the data bit is taken at the first clock edge that sees the strobe newly asserted, and later changes of the data wire are ignored. The acknowledge is pulled from that edge onward and released at the edge that sees the strobe high.
- R5: Each byte is 8 bits and is sent most significant bit first. The receiver rebuilds the byte in the same order.
- R6: In the receiver role, rxValid is high for exactly one cycle, starting at the edge that sees the strobe released after the eighth bit. rxData holds the byte while rxValid is high.
- R7: txReady is high only while the block is idle in the sender role. A byte is accepted on a cycle where both txValid and txReady are high.
- R8: Any added delay from the partner, whether before acknowledging, before releasing the acknowledge, before strobing or before releasing the strobe, changes only the pace and never the data that is delivered.
- R9: When a handshake wait goes on for more than timeoutLimit cycles, the byte is abandoned, all wires are released, the block returns to idle and timeoutFlag is set. The flag stays set through later traffic until reset.
- R10: A synchronous reset returns the block to idle with all wires released, rxValid low and timeoutFlag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| roleSend | input | 1 | 1 selects the sender role, 0 the receiver role |
| txData | input | DATA_W | Byte to send |
| txValid | input | 1 | txData is valid |
| txReady | output | 1 | Sender idle and able to take a byte |
| rxData | output | DATA_W | Last received byte |
| rxValid | output | 1 | One-cycle pulse when a byte has been received |
| timeoutLimit | input | TO_W | Longest allowed handshake wait, in cycles |
| timeoutFlag | output | 1 | Sticky flag showing that a wait was abandoned |
| dataIn | input | 1 | Sensed level of the data wire |
| dataPullLow | output | 1 | Pull the data wire low |
| strobeIn | input | 1 | Sensed level of the strobe wire |
| strobePullLow | output | 1 | Pull the strobe wire low |
| ackIn | input | 1 | Sensed level of the acknowledge wire |
| ackPullLow | output | 1 | Pull the acknowledge wire low |

## Verification
Bytes of all ones, all zeros, alternating bits and patterns with the end bits set are sent and received. These show whether the bit order and the low-means-one polarity are right. Each role is run once against a partner that answers at once and once against a partner that stalls at every handshake phase; the stalling partner shows whether the block waits on the wires rather than on a count of cycles. In the receiver tests the data wire is flipped while the strobe is held, which shows whether the bit is taken only at the strobe edge. In the stall tests the partner never answers, which separates a timely abort from a hang, and the traffic that follows shows that the flag stays set.

// File: rtl/linkPkg.sv
package linkPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_RELEASE,
    ST_ACK,
    ST_RXWAIT
  } linkStateT;

  typedef struct packed {
    logic loadTx;
    logic shiftTx;
    logic captureRx;
    logic cntClear;
    logic cntInc;
    logic waitClear;
  } linkStrobeT;

endpackage

// File: rtl/linkDatapath.sv
module linkDatapath
  import linkPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TO_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  linkStrobeT        strb,
  input  logic [DATA_W-1:0] txData,
  input  logic              dataIn,
  input  logic [TO_W-1:0]   timeoutLimit,
  output logic              txBit,
  output logic [DATA_W-1:0] rxData,
  output logic              lastBit,
  output logic              timeoutHit
);

  localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] shiftReg;
  logic [CNT_W-1:0]  bitCnt;
  logic [TO_W-1:0]   waitCnt;

  // one register serves both roles: MSB leaves first, new bits enter at LSB
  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg <= '0;
    end else if (strb.loadTx) begin
      shiftReg <= txData;
    end else if (strb.shiftTx) begin
      shiftReg <= {shiftReg[DATA_W-2:0], 1'b0};
    end else if (strb.captureRx) begin
      shiftReg <= {shiftReg[DATA_W-2:0], ~dataIn};
    end
  end

  always_ff @(posedge clk) begin
    if (rst || strb.cntClear) begin
      bitCnt <= '0;
    end else if (strb.cntInc) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  // saturating wait counter, cleared whenever a wait phase is entered
  always_ff @(posedge clk) begin
    if (rst || strb.waitClear) begin
      waitCnt <= '0;
    end else if (waitCnt != '1) begin
      waitCnt <= waitCnt + 1'b1;
    end
  end

  assign txBit      = shiftReg[DATA_W-1];
  assign rxData     = shiftReg;
  assign lastBit    = (bitCnt == LAST_IDX);
  assign timeoutHit = (waitCnt >= timeoutLimit);

  assert_count_bounded_R5: assert property (@(posedge clk) disable iff (rst)
    strb.cntInc |-> (bitCnt != LAST_IDX));

endmodule

// File: rtl/linkCtrl.sv
module linkCtrl
  import linkPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       roleSend,
  input  logic       txValid,
  input  logic       strobeIn,
  input  logic       ackIn,
  input  logic       txBit,
  input  logic       lastBit,
  input  logic       timeoutHit,
  output linkStrobeT strb,
  output logic       txReady,
  output logic       rxValid,
  output logic       timeoutFlag,
  output logic       dataPullLow,
  output logic       strobePullLow,
  output logic       ackPullLow
);

  linkStateT state, nxt;
  logic      strobePrev;
  logic      strobeFell;
  logic      abortNow;
  logic      rxDone;

  assign strobeFell = strobePrev && !strobeIn;

  always_comb begin
    nxt      = state;
    strb     = '0;
    abortNow = 1'b0;
    rxDone   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (roleSend) begin
          if (txValid) begin
            strb.loadTx   = 1'b1;
            strb.cntClear = 1'b1;
            nxt           = ST_SETUP;
          end
        end else if (strobeFell) begin
          strb.captureRx = 1'b1;
          strb.cntClear  = 1'b1;
          strb.waitClear = 1'b1;
          nxt            = ST_ACK;
        end
      end
      ST_SETUP: begin
        strb.waitClear = 1'b1;
        nxt            = ST_STROBE;
      end
      ST_STROBE: begin
        if (!ackIn) begin
          strb.waitClear = 1'b1;
          nxt            = ST_RELEASE;
        end else if (timeoutHit) begin
          abortNow = 1'b1;
        end
      end
      ST_RELEASE: begin
        if (ackIn) begin
          if (lastBit) begin
            nxt = ST_IDLE;
          end else begin
            strb.shiftTx = 1'b1;
            strb.cntInc  = 1'b1;
            nxt          = ST_SETUP;
          end
        end else if (timeoutHit) begin
          abortNow = 1'b1;
        end
      end
      ST_ACK: begin
        if (strobeIn) begin
          if (lastBit) begin
            rxDone = 1'b1;
            nxt    = ST_IDLE;
          end else begin
            strb.cntInc    = 1'b1;
            strb.waitClear = 1'b1;
            nxt            = ST_RXWAIT;
          end
        end else if (timeoutHit) begin
          abortNow = 1'b1;
        end
      end
      ST_RXWAIT: begin
        if (strobeFell) begin
          strb.captureRx = 1'b1;
          strb.waitClear = 1'b1;
          nxt            = ST_ACK;
        end else if (timeoutHit) begin
          abortNow = 1'b1;
        end
      end
      default: nxt = ST_IDLE;
    endcase
    if (abortNow) nxt = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      strobePrev  <= 1'b1;
      rxValid     <= 1'b0;
      timeoutFlag <= 1'b0;
    end else begin
      state      <= nxt;
      strobePrev <= strobeIn;
      rxValid    <= rxDone;
      if (abortNow) timeoutFlag <= 1'b1;
    end
  end

  assign txReady       = (state == ST_IDLE) && roleSend;
  assign dataPullLow   = txBit && ((state == ST_SETUP) || (state == ST_STROBE) ||
                                   (state == ST_RELEASE));
  assign strobePullLow = (state == ST_STROBE);
  assign ackPullLow    = (state == ST_ACK);

  assert_data_held_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && strobePullLow && $past(strobePullLow)) |-> $stable(dataPullLow));

  assert_strobe_waits_R3: assert property (@(posedge clk) disable iff (rst)
    (strobePullLow && ackIn) |=> (strobePullLow || timeoutFlag));

  assert_ack_after_strobe_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(ackPullLow) |-> !$past(strobeIn));

  assert_rx_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    rxValid |=> !rxValid);

  assert_ready_role_R7: assert property (@(posedge clk) disable iff (rst)
    txReady |-> (roleSend && !strobePullLow && !ackPullLow));

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(timeoutFlag)) |-> timeoutFlag);

  assert_reset_idle_R10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!dataPullLow && !strobePullLow && !ackPullLow && !rxValid && !timeoutFlag));

endmodule

// File: rtl/ackSerialLink.sv
module ackSerialLink
  import linkPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TO_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              roleSend,
  input  logic [DATA_W-1:0] txData,
  input  logic              txValid,
  output logic              txReady,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  input  logic [TO_W-1:0]   timeoutLimit,
  output logic              timeoutFlag,
  input  logic              dataIn,
  output logic              dataPullLow,
  input  logic              strobeIn,
  output logic              strobePullLow,
  input  logic              ackIn,
  output logic              ackPullLow
);

  linkStrobeT strb;
  logic       txBit;
  logic       lastBit;
  logic       timeoutHit;

  linkDatapath #(.DATA_W(DATA_W), .TO_W(TO_W)) i_datapath (
    .clk          (clk),
    .rst          (rst),
    .strb         (strb),
    .txData       (txData),
    .dataIn       (dataIn),
    .timeoutLimit (timeoutLimit),
    .txBit        (txBit),
    .rxData       (rxData),
    .lastBit      (lastBit),
    .timeoutHit   (timeoutHit)
  );

  linkCtrl i_ctrl (
    .clk           (clk),
    .rst           (rst),
    .roleSend      (roleSend),
    .txValid       (txValid),
    .strobeIn      (strobeIn),
    .ackIn         (ackIn),
    .txBit         (txBit),
    .lastBit       (lastBit),
    .timeoutHit    (timeoutHit),
    .strb          (strb),
    .txReady       (txReady),
    .rxValid       (rxValid),
    .timeoutFlag   (timeoutFlag),
    .dataPullLow   (dataPullLow),
    .strobePullLow (strobePullLow),
    .ackPullLow    (ackPullLow)
  );

  assert_abort_releases_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(timeoutFlag) |-> (!dataPullLow && !strobePullLow && !ackPullLow));

endmodule

// File: tb/test_ackSerialLink.sv
module test_ackSerialLink;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 8;
  localparam int TO_W   = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic roleSend = 1'b1;
  logic [DATA_W-1:0] txData = '0;
  logic txValid = 1'b0;
  logic txReady;
  logic [DATA_W-1:0] rxData;
  logic rxValid;
  logic [TO_W-1:0] timeoutLimit = 16'd100;
  logic timeoutFlag;
  logic dutDataPull, dutStrobePull, dutAckPull;
  logic tbDataPull = 1'b0, tbStrobePull = 1'b0, tbAckPull = 1'b0;
  logic dataLine, strobeLine, ackLine;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  assign dataLine   = ~(dutDataPull | tbDataPull);
  assign strobeLine = ~(dutStrobePull | tbStrobePull);
  assign ackLine    = ~(dutAckPull | tbAckPull);

  always #(CLK_PERIOD/2) clk = ~clk;

  ackSerialLink #(.DATA_W(DATA_W), .TO_W(TO_W)) i_ackSerialLink (
    .clk(clk), .rst(rst), .roleSend(roleSend), .txData(txData), .txValid(txValid),
    .txReady(txReady), .rxData(rxData), .rxValid(rxValid), .timeoutLimit(timeoutLimit),
    .timeoutFlag(timeoutFlag), .dataIn(dataLine), .dataPullLow(dutDataPull),
    .strobeIn(strobeLine), .strobePullLow(dutStrobePull), .ackIn(ackLine),
    .ackPullLow(dutAckPull)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    rst = 1'b1;
    tbDataPull = 0; tbStrobePull = 0; tbAckPull = 0; txValid = 0;
    repeat (3) tick();
    rst = 1'b0;
    tick();
  endtask

  // bench acts as receiver; DUT sends val
  task automatic sendByte(input logic [7:0] val, input int ackDelay, input int relDelay);
    logic [7:0] got = '0;
    logic prevD;
    int guard;
    roleSend = 1'b1;
    tick();
    check(txReady == 1'b1, "R7 ready when idle sender", int'(txReady), 1);
    txData = val; txValid = 1'b1;
    tick();
    txValid = 1'b0;
    check(txReady == 1'b0, "R7 ready drops after accept", int'(txReady), 0);
    for (int b = 0; b < 8; b++) begin
      guard = 0;
      do begin
        prevD = dataLine;
        tick();
        guard++;
      end while (strobeLine && guard < 1000);
      check(guard < 1000, "R3 strobe appears", guard, 0);
      check(dataLine == prevD, "R2 data set up before strobe", int'(dataLine), int'(prevD));
      got = {got[6:0], ~dataLine};
      for (int d = 0; d < ackDelay; d++) begin
        tick();
        check(strobeLine == 1'b0, "R3 strobe held until ack", int'(strobeLine), 0);
      end
      tbAckPull = 1'b1;
      tick();
      check(strobeLine == 1'b1, "R3 strobe released after ack", int'(strobeLine), 1);
      for (int d = 0; d < relDelay; d++) begin
        check(dataLine == prevD, "R2 data held until ack release", int'(dataLine), int'(prevD));
        check(strobeLine == 1'b1, "R3 no new strobe before ack release", int'(strobeLine), 1);
        tick();
      end
      tbAckPull = 1'b0;
    end
    tick();
    check(got == val, "R5 R8 R1 sent byte msb first", int'(got), int'(val));
    check(txReady == 1'b1, "R7 ready after byte", int'(txReady), 1);
  endtask

  // bench acts as sender; DUT receives
  task automatic recvByte(input logic [7:0] val, input int gapDelay, input int holdDelay);
    roleSend = 1'b0;
    tick();
    for (int b = 7; b >= 0; b--) begin
      tbDataPull = val[b];
      tick();
      tbStrobePull = 1'b1;
      tick();
      check(ackLine == 1'b0, "R4 ack after strobe", int'(ackLine), 0);
      tbDataPull = ~val[b];
      for (int d = 0; d < holdDelay; d++) begin
        tick();
        check(ackLine == 1'b0, "R4 ack held while strobe", int'(ackLine), 0);
      end
      tbStrobePull = 1'b0;
      tick();
      check(ackLine == 1'b1, "R4 ack released", int'(ackLine), 1);
      if (b == 0) begin
        check(rxValid == 1'b1, "R6 valid pulse", int'(rxValid), 1);
        check(rxData == val, "R5 R8 R1 received byte", int'(rxData), int'(val));
        tick();
        check(rxValid == 1'b0, "R6 valid one cycle", int'(rxValid), 0);
      end else begin
        check(rxValid == 1'b0, "R6 no early valid", int'(rxValid), 0);
      end
      tbDataPull = 1'b0;
      repeat (gapDelay) tick();
    end
  endtask

  task automatic testReset();
    doReset();
    check(!dutDataPull && !dutStrobePull && !dutAckPull, "R10 lines released", 0, 0);
    check(rxValid == 1'b0, "R10 rxValid low", int'(rxValid), 0);
    check(timeoutFlag == 1'b0, "R10 flag clear", int'(timeoutFlag), 0);
    roleSend = 1'b1; txData = 8'hFF; txValid = 1'b1;
    repeat (3) tick();
    txValid = 1'b0;
    rst = 1'b1; tick(); rst = 1'b0; tick();
    check(dataLine && strobeLine && ackLine, "R10 reset mid-byte releases lines",
          int'({dataLine, strobeLine, ackLine}), 7);
  endtask

  task automatic testSendTimeout();
    doReset();
    timeoutLimit = 16'd8;
    roleSend = 1'b1; txData = 8'h80; txValid = 1'b1;
    tick(); txValid = 1'b0;
    repeat (4) tick();
    check(timeoutFlag == 1'b0, "R9 no flag before limit", int'(timeoutFlag), 0);
    repeat (20) tick();
    check(timeoutFlag == 1'b1, "R9 sender timeout flag", int'(timeoutFlag), 1);
    check(strobeLine && dataLine, "R9 sender lines released", int'({dataLine, strobeLine}), 3);
    check(txReady == 1'b1, "R9 sender back to idle", int'(txReady), 1);
    sendByte(8'h5A, 1, 2);
    check(timeoutFlag == 1'b1, "R9 flag sticky", int'(timeoutFlag), 1);
    timeoutLimit = 16'd100;
  endtask

  task automatic testRecvTimeout();
    doReset();
    timeoutLimit = 16'd6;
    roleSend = 1'b0; tick();
    tbStrobePull = 1'b1; tick();
    check(ackLine == 1'b0, "R4 ack asserted", int'(ackLine), 0);
    repeat (20) tick();
    check(timeoutFlag == 1'b1, "R9 receiver timeout flag", int'(timeoutFlag), 1);
    check(ackLine == 1'b1, "R9 ack released on abort", int'(ackLine), 1);
    tbStrobePull = 1'b0; tick();
    recvByte(8'hC3, 0, 0);
    check(timeoutFlag == 1'b1, "R9 flag stays set after traffic", int'(timeoutFlag), 1);
    timeoutLimit = 16'd100;
  endtask

  initial begin
    testReset();
    doReset();
    sendByte(8'hA5, 0, 0);
    sendByte(8'h00, 0, 0);
    sendByte(8'hFF, 5, 7);
    sendByte(8'h81, 3, 0);
    recvByte(8'h3C, 0, 0);
    recvByte(8'hFF, 4, 3);
    recvByte(8'h01, 2, 0);
    recvByte(8'h80, 0, 5);
    testSendTimeout();
    testRecvTimeout();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule